// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Classify Unit

This unit handles the non-arithmetic single-precision operations of a floating-point datapath. It takes two IEEE-754 binary32 operands and a 4-bit operation code. It returns a 32-bit result and a 5-bit exception flag vector. The compare and classify operations produce an integer-style result, which is a boolean or a class mask. Minimum, maximum and the three sign-injection forms produce a float bit pattern. None of these operations rounds. The only flag they can raise is invalid-operation.

The operand decode, ordering and result selection are all combinational. The result and the flags are captured in one output register stage, so a request presented at a rising edge of `clk_i` appears on the outputs one cycle later. A new request may be presented every cycle.

Operation codes on `op_i`:
- 0: equal
- 1: less-than
- 2: less-or-equal
- 3: minimum
- 4: maximum
- 5: copy sign
- 6: copy inverted sign
- 7: XOR sign
- 8: classify
- 9 to 15: unused

Top module: `fpcc_unit`

## Requirements
- R1: For non-NaN operands, op 0 returns 1 when the operands are numerically equal, with +0 and -0 equal. Op 1 returns 1 when A < B and op 2 returns 1 when A <= B; when both operands are negative, the order of the magnitudes is reversed. Otherwise the result is 0, and bits 31..1 are always zero.
- R2: Ops 0, 1 and 2 return 0 whenever either operand is a NaN, which means exponent all ones and a nonzero significand.
- R3: Ops 1 and 2 set the invalid flag for any NaN operand. Op 0 sets it only when an operand is a signaling NaN, which has significand bit 22 clear.
- R4: Ops 3 and 4 return the smaller or the larger operand bit pattern. For this ordering only, -0 is less than +0.
- R5: For ops 3 and 4, two NaN operands give 0x7FC00000. A single NaN operand gives the other operand unchanged.
- R6: For ops 3 and 4, any signaling NaN operand sets the invalid flag, even when the result is not a NaN. Quiet NaNs set no flag.
- R7: Ops 5, 6 and 7 return bits 30..0 of A, with no NaN canonicalization. The sign is B's sign (op 5), its inverse (op 6), or A's sign XOR B's sign (op 7).
- R8: Ops 5 to 8 never raise any flag.
- R9: Op 8 returns a one-hot mask in bits 9..0 with bits 31..10 zero. The bits, from 0 to 9, are: -inf, negative normal, negative subnormal, -0, +0, positive subnormal, positive normal, +inf, signaling NaN, quiet NaN.
- R10: The invalid flag is bit 4 of `flags_o`. Bits 3..0 are always zero. Ops 9 to 15 give a zero result and zero flags.
- R11: Reset clears both outputs. Each result appears one clock after its operands and code are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Operand A (binary32) |
| opb_i | input | 32 | Operand B (binary32) |
| result_o | output | 32 | Registered result |
| flags_o | output | 5 | Registered exception flags, invalid at bit 4 |

## Verification
A min or max on a signaling NaN produces a valid numeric result and raises the invalid flag in the same cycle. A correct result therefore does not prove that the flag is correct. The bench provokes this case with directed pairs of a signaling NaN and a number, and with random draws from a pool that is rich in NaN patterns. Each output cycle is judged on the result word and the flag vector together, against a model that orders values through signed integer keys.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int FLAG_W    = 5;
  localparam int FLAG_NV   = 4;
  localparam int CLASS_W   = 10;
  localparam int OP_W      = 4;

  typedef enum logic [OP_W-1:0] {
    OP_EQ    = 4'd0,
    OP_LT    = 4'd1,
    OP_LE    = 4'd2,
    OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,
    OP_SGNJ  = 4'd5,
    OP_SGNJN = 4'd6,
    OP_SGNJX = 4'd7,
    OP_CLASS = 4'd8
  } fpcc_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic subnorm;
    logic norm;
    logic inf;
    logic nan;
    logic snan;
    logic qnan;
  } fpcc_kind_t;

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output fpcc_kind_t           kind_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones, exp_zero, man_zero;

  assign exp_f    = val_i[W-2 -: EXP_W];
  assign man_f    = val_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  always_comb begin
    kind_o         = '0;
    kind_o.sign    = val_i[W-1];
    kind_o.zero    = exp_zero & man_zero;
    kind_o.subnorm = exp_zero & ~man_zero;
    kind_o.norm    = ~exp_zero & ~exp_ones;
    kind_o.inf     = exp_ones & man_zero;
    kind_o.nan     = exp_ones & ~man_zero;
    // quiet bit is the significand MSB
    kind_o.qnan    = kind_o.nan & man_f[MAN_W-1];
    kind_o.snan    = kind_o.nan & ~man_f[MAN_W-1];
  end

endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  fpcc_kind_t           ka_i,
  input  fpcc_kind_t           kb_i,
  output logic                 eq_o,
  output logic                 lt_o,
  output logic                 tot_lt_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-2:0] mag_a, mag_b;
  logic         mag_lt, mag_gt, sign_diff, both_zero;

  assign mag_a     = a_i[W-2:0];
  assign mag_b     = b_i[W-2:0];
  assign mag_lt    = mag_a < mag_b;
  assign mag_gt    = mag_b < mag_a;
  assign sign_diff = ka_i.sign ^ kb_i.sign;
  assign both_zero = ka_i.zero & kb_i.zero;

  // numeric equality: signed zeros match
  assign eq_o = both_zero | (a_i == b_i);

  // numeric less-than
  always_comb begin
    if (both_zero)      lt_o = 1'b0;
    else if (sign_diff) lt_o = ka_i.sign;
    else if (ka_i.sign) lt_o = mag_gt;
    else                lt_o = mag_lt;
  end

  // total order for min/max: -0 below +0
  always_comb begin
    if (sign_diff)      tot_lt_o = ka_i.sign;
    else if (ka_i.sign) tot_lt_o = mag_gt;
    else                tot_lt_o = mag_lt;
  end

endmodule

// File: rtl/fpcc_select.sv
module fpcc_select
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [OP_W-1:0]      op_i,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  fpcc_kind_t           ka_i,
  input  fpcc_kind_t           kb_i,
  input  logic                 eq_i,
  input  logic                 lt_i,
  input  logic                 tot_lt_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic [FLAG_W-1:0]    flags_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic         any_nan, any_snan;
  logic [W-1:0] min_pick, max_pick, class_word;
  logic [CLASS_W-1:0] class_mask;

  assign any_nan  = ka_i.nan | kb_i.nan;
  assign any_snan = ka_i.snan | kb_i.snan;

  always_comb begin
    if (ka_i.nan & kb_i.nan) begin
      min_pick = CANON_NAN;
      max_pick = CANON_NAN;
    end else if (ka_i.nan) begin
      min_pick = b_i;
      max_pick = b_i;
    end else if (kb_i.nan) begin
      min_pick = a_i;
      max_pick = a_i;
    end else begin
      min_pick = tot_lt_i ? a_i : b_i;
      max_pick = tot_lt_i ? b_i : a_i;
    end
  end

  always_comb begin
    class_mask    = '0;
    class_mask[0] = ka_i.inf & ka_i.sign;
    class_mask[1] = ka_i.norm & ka_i.sign;
    class_mask[2] = ka_i.subnorm & ka_i.sign;
    class_mask[3] = ka_i.zero & ka_i.sign;
    class_mask[4] = ka_i.zero & ~ka_i.sign;
    class_mask[5] = ka_i.subnorm & ~ka_i.sign;
    class_mask[6] = ka_i.norm & ~ka_i.sign;
    class_mask[7] = ka_i.inf & ~ka_i.sign;
    class_mask[8] = ka_i.snan;
    class_mask[9] = ka_i.qnan;
    class_word    = W'(class_mask);
  end

  always_comb begin
    res_o   = '0;
    flags_o = '0;
    case (op_i)
      OP_EQ: begin
        res_o[0]         = ~any_nan & eq_i;
        flags_o[FLAG_NV] = any_snan;
      end
      OP_LT: begin
        res_o[0]         = ~any_nan & lt_i;
        flags_o[FLAG_NV] = any_nan;
      end
      OP_LE: begin
        res_o[0]         = ~any_nan & (lt_i | eq_i);
        flags_o[FLAG_NV] = any_nan;
      end
      OP_MIN: begin
        res_o            = min_pick;
        flags_o[FLAG_NV] = any_snan;
      end
      OP_MAX: begin
        res_o            = max_pick;
        flags_o[FLAG_NV] = any_snan;
      end
      OP_SGNJ:  res_o = {kb_i.sign, a_i[W-2:0]};
      OP_SGNJN: res_o = {~kb_i.sign, a_i[W-2:0]};
      OP_SGNJX: res_o = {ka_i.sign ^ kb_i.sign, a_i[W-2:0]};
      OP_CLASS: res_o = class_word;
      default: begin
        res_o   = '0;
        flags_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [OP_W-1:0]      op_i,
  input  logic [EXP_W+MAN_W:0] opa_i,
  input  logic [EXP_W+MAN_W:0] opb_i,
  output logic [EXP_W+MAN_W:0] result_o,
  output logic [FLAG_W-1:0]    flags_o
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][W-1:0] opnd;
  fpcc_kind_t [N_OPS-1:0]  kind;
  logic                    eq, lt, tot_lt;
  logic [W-1:0]            res_d;
  logic [FLAG_W-1:0]       flags_d;

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_dec
    fpcc_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
      .val_i  (opnd[g]),
      .kind_o (kind[g])
    );
  end

  fpcc_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .ka_i     (kind[0]),
    .kb_i     (kind[1]),
    .eq_o     (eq),
    .lt_o     (lt),
    .tot_lt_o (tot_lt)
  );

  fpcc_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .op_i     (op_i),
    .a_i      (opa_i),
    .b_i      (opb_i),
    .ka_i     (kind[0]),
    .kb_i     (kind[1]),
    .eq_i     (eq),
    .lt_i     (lt),
    .tot_lt_i (tot_lt),
    .res_o    (res_d),
    .flags_o  (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= res_d;
      flags_o  <= flags_d;
    end
  end

endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker
  import fpcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [OP_W-1:0]      op_i,
  input logic [EXP_W+MAN_W:0] opa_i,
  input logic [EXP_W+MAN_W:0] opb_i,
  input logic [EXP_W+MAN_W:0] result_o,
  input logic [FLAG_W-1:0]    flags_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic a_is_nan, b_is_nan;
  assign a_is_nan = (opa_i[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (opa_i[MAN_W-1:0] != '0);
  assign b_is_nan = (opb_i[W-2 -: EXP_W] == {EXP_W{1'b1}}) && (opb_i[MAN_W-1:0] != '0);

  AST_LOW_FLAGS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLAG_NV-1:0] == '0);  // R10

  AST_CMP_BOOLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd2) |=> (result_o[W-1:1] == '0));  // R1

  AST_CMP_NAN_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i <= 4'd2) && (a_is_nan || b_is_nan)) |=> (result_o == '0));  // R2

  AST_ORDERED_NAN_NV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd1 || op_i == 4'd2) && (a_is_nan || b_is_nan)) |=> flags_o[FLAG_NV]);  // R3

  AST_MINMAX_PICKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd3 || op_i == 4'd4) && !a_is_nan && !b_is_nan)
      |=> (result_o == $past(opa_i) || result_o == $past(opb_i)));  // R4

  AST_SGNJ_BODY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd5 && op_i <= 4'd7) |=> (result_o[W-2:0] == $past(opa_i[W-2:0])));  // R7

  AST_QUIET_OPS_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd5 && op_i <= 4'd8) |=> (flags_o == '0));  // R8

  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd8) |=> ($countones(result_o[CLASS_W-1:0]) == 1
                        && result_o[W-1:CLASS_W] == '0));  // R9

  AST_UNUSED_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd8) |=> (result_o == '0 && flags_o == '0));  // R10

endmodule

bind fpcc_unit fpcc_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/sim_fpcc_unit.sv
module sim_fpcc_unit;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  fpcc_unit u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .result_o (result_o),
    .flags_o  (flags_o)
  );

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction

  // numeric key: both zeros map to 0
  function automatic longint key_num(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  // total-order key: -0 sits below +0
  function automatic longint key_tot(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m - 1 : m;
  endfunction

  function automatic int class_idx(logic [31:0] x);
    if (is_nan(x)) return x[22] ? 9 : 8;
    if (x[30:23] == 8'hFF) return x[31] ? 0 : 7;
    if (x[30:0] == 0) return x[31] ? 3 : 4;
    if (x[30:23] == 0) return x[31] ? 2 : 5;
    return x[31] ? 1 : 6;
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [4:0] f);
    bit an = is_nan(a), bn = is_nan(b);
    bit sn = is_snan(a) || is_snan(b);
    r = 0; f = 0;
    case (op)
      0: begin r = (!an && !bn && key_num(a) == key_num(b)) ? 1 : 0; f[4] = sn; end
      1: begin r = (!an && !bn && key_num(a) <  key_num(b)) ? 1 : 0; f[4] = an || bn; end
      2: begin r = (!an && !bn && key_num(a) <= key_num(b)) ? 1 : 0; f[4] = an || bn; end
      3, 4: begin
        if (an && bn) r = 32'h7FC00000;
        else if (an) r = b;
        else if (bn) r = a;
        else if (op == 3) r = (key_tot(a) < key_tot(b)) ? a : b;
        else r = (key_tot(a) > key_tot(b)) ? a : b;
        f[4] = sn;
      end
      5: r = {b[31], a[30:0]};
      6: r = {!b[31], a[30:0]};
      7: r = {a[31] != b[31], a[30:0]};
      8: r = 32'd1 << class_idx(a);
      default: r = 0;
    endcase
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      0, 1, 2: return "R1";
      3, 4:    return "R4";
      5, 6, 7: return "R7";
      8:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] r_exp, logic [4:0] f_exp);
    checks++;
    if (result_o !== r_exp || flags_o !== f_exp) begin
      fails++;
      $display("FAIL %s: result=%08h flags=%02h expected result=%08h flags=%02h",
               req, result_o, flags_o, r_exp, f_exp);
    end
  endtask

  // drive at negedge, result captured at next posedge, sample 1 ns after it
  task automatic apply(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [31:0] r_exp, logic [4:0] f_exp);
    logic [31:0] mr; logic [4:0] mf;
    @(negedge clk_i);
    op_i = op; opa_i = a; opb_i = b;
    @(posedge clk_i); #1;
    check(req, r_exp, f_exp);
    model(op, a, b, mr, mf);
    check({req, "-model"}, mr, mf);
  endtask

  logic [31:0] pool [15] = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
                             32'h40000000, 32'hC0000000, 32'h7F800000, 32'hFF800000,
                             32'h7FC00000, 32'h7FC12345, 32'h7F800001, 32'hFFA00000,
                             32'h00000001, 32'h807FFFFF, 32'h7F7FFFFF};

  function automatic logic [31:0] pick();
    if ($urandom_range(0, 9) < 7) return pool[$urandom_range(0, 14)];
    return $urandom;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R11 reset", 32'h0, 5'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: compares on ordinary values
    apply("R1 eq signed zeros", 0, 32'h00000000, 32'h80000000, 32'h1, 5'h00);
    apply("R1 lt negatives",    1, 32'hC0000000, 32'hBF800000, 32'h1, 5'h00);
    apply("R1 lt reversed",     1, 32'hBF800000, 32'hC0000000, 32'h0, 5'h00);
    apply("R1 le equal",        2, 32'hBF800000, 32'hBF800000, 32'h1, 5'h00);
    apply("R1 lt -0 vs +0",     1, 32'h80000000, 32'h00000000, 32'h0, 5'h00);
    // R2, R3: NaN compares
    apply("R2 R3 lt qnan",      1, 32'h3F800000, 32'h7FC00000, 32'h0, 5'h10);
    apply("R2 R3 eq qnan",      0, 32'h7FC00000, 32'h3F800000, 32'h0, 5'h00);
    apply("R2 R3 eq snan",      0, 32'h7F800001, 32'h7F800001, 32'h0, 5'h10);
    apply("R3 le qnan",         2, 32'h7FC12345, 32'h7FC12345, 32'h0, 5'h10);
    // R4: min/max signed zeros and ordering
    apply("R4 min zeros",       3, 32'h00000000, 32'h80000000, 32'h80000000, 5'h00);
    apply("R4 max zeros",       4, 32'h80000000, 32'h00000000, 32'h00000000, 5'h00);
    apply("R4 max negatives",   4, 32'hC0000000, 32'hBF800000, 32'hBF800000, 5'h00);
    // R5: NaN handling
    apply("R5 min two nans",    3, 32'h7FC12345, 32'hFFA00000, 32'h7FC00000, 5'h10);
    apply("R5 max one qnan",    4, 32'h7FC00000, 32'hC0000000, 32'hC0000000, 5'h00);
    // R6: signaling NaN flags with numeric result
    apply("R6 min snan num",    3, 32'h7F800001, 32'h3F800000, 32'h3F800000, 5'h10);
    apply("R6 max num snan",    4, 32'hBF800000, 32'hFFA00000, 32'hBF800000, 5'h10);
    // R7, R8: sign injection
    apply("R7 R8 sgnjn snan",   6, 32'h7F800001, 32'h3F800000, 32'hFF800001, 5'h00);
    apply("R7 sgnjx",           7, 32'hBF800000, 32'hC0000000, 32'h3F800000, 5'h00);
    apply("R7 sgnj",            5, 32'h3F800000, 32'h80000000, 32'hBF800000, 5'h00);
    // R9, R8: classify each class
    apply("R9 -inf",    8, 32'hFF800000, 32'h7F800001, 32'h001, 5'h00);
    apply("R9 -norm",   8, 32'hBF800000, 32'h0, 32'h002, 5'h00);
    apply("R9 -sub",    8, 32'h807FFFFF, 32'h0, 32'h004, 5'h00);
    apply("R9 -0",      8, 32'h80000000, 32'h0, 32'h008, 5'h00);
    apply("R9 +0",      8, 32'h00000000, 32'h0, 32'h010, 5'h00);
    apply("R9 +sub",    8, 32'h00000001, 32'h0, 32'h020, 5'h00);
    apply("R9 +norm",   8, 32'h7F7FFFFF, 32'h0, 32'h040, 5'h00);
    apply("R9 +inf",    8, 32'h7F800000, 32'h0, 32'h080, 5'h00);
    apply("R9 R8 snan", 8, 32'h7F800001, 32'h0, 32'h100, 5'h00);
    apply("R9 qnan",    8, 32'hFFC00000, 32'h0, 32'h200, 5'h00);
    // R10: unused code
    apply("R10 unused op", 12, 32'h7F800001, 32'hFFA00000, 32'h0, 5'h00);
    // R11: back-to-back codes, each result one clock later
    apply("R11 back-to-back a", 1, 32'h00000000, 32'h3F800000, 32'h1, 5'h00);
    apply("R11 back-to-back b", 1, 32'h3F800000, 32'h00000000, 32'h0, 5'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op = 4'($urandom_range(0, 9));
      logic [31:0] a = pick();
      logic [31:0] b = pick();
      logic [31:0] mr; logic [4:0] mf;
      model(op, a, b, mr, mf);
      @(negedge clk_i);
      op_i = op; opa_i = a; opb_i = b;
      @(posedge clk_i); #1;
      check(req_of(op), mr, mf);
    end

    // R11: asynchronous reset clears outputs
    @(negedge clk_i);
    op_i = 4'd7; opa_i = 32'hBF800000; opb_i = 32'h0;
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    check("R11 async reset", 32'h0, 5'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule